// File: doc/BRIEF.md
# Fused multiply-add NaN operand selector

This block decides which NaN a fused multiply-add unit computing (a*b)+c should return when at least one operand is a NaN, or when the product is infinity times zero. It receives a two-bit class code for each of the three operands, an infinity-times-zero indicator from the multiplier's special-case logic, a three-bit policy select and a first-NaN mode bit. It returns a two-bit choice naming operand a, b, c or the default NaN, an invalid-operation flag and a separate invalid-multiply-by-zero sub-flag.

The policies differ in two ways: the order in which they rank the addend against the multiplicands, and how they treat the infinity-times-zero product. Some return the default NaN, some pass the addend through, and one does so only when the addend is a quiet NaN. The datapath uses the choice to steer its result multiplexer. Quieting of a signaling NaN and the arithmetic itself happen elsewhere.

Top module: `fma_nan_select`

## Requirements
- R1: Class codes are 2'b00 and 2'b01 for non-NaN values, 2'b10 for a quiet NaN and 2'b11 for a signaling NaN. The choice encodes 0 = a, 1 = b, 2 = c, 3 = default NaN. Outputs are registered and reflect the inputs one clock later. Reset drives the choice to 3 and both flags to 0.
- R2: Policy 0: infinity-times-zero with c a quiet NaN gives choice 3 with invalid. Otherwise the first match among signaling c, a, b, then quiet c, a, wins, else b; no invalid.
- R3: Policy 1: infinity-times-zero always gives choice 3 with invalid. Otherwise signaling NaNs win in a, b, c order, then quiet NaNs in a, b order, else c.
- R4: Policy 2: infinity-times-zero gives choice 2 with invalid. Otherwise signaling NaNs win in c, a, b order, then quiet NaNs in c, a order, else b.
- R5: Policy 3: infinity-times-zero gives choice 2 with invalid. Otherwise a if it is any NaN, else c if it is any NaN, else b.
- R6: Policy 4: the choice is always 3; invalid is raised exactly when infinity-times-zero is set.
- R7: Policy 5 with the first-NaN mode bit set: infinity-times-zero gives choice 2 with invalid; otherwise the first of a, b that is any NaN, else c.
- R8: Policy 5 with the mode bit clear: infinity-times-zero gives choice 2 with invalid; otherwise the first of c, b that is any NaN, else a.
- R9: Policy codes 6 and 7: the first of a, b that is any NaN, else c; infinity-times-zero has no effect and no flag is raised.
- R10: The multiply-by-zero sub-flag is high in exactly the cycles where invalid is high, and invalid is only ever raised for an infinity-times-zero input.
- R11: The first-NaN mode bit has no effect on any output under policies other than 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 3 | Propagation policy select |
| first_nan_i | input | 1 | First-NaN mode bit, used by policy 5 |
| inf_zero_i | input | 1 | Product is infinity times zero |
| cls_a_i | input | 2 | Class code of multiplicand a |
| cls_b_i | input | 2 | Class code of multiplicand b |
| cls_c_i | input | 2 | Class code of addend c |
| pick_o | output | 2 | Selected operand or default NaN |
| invalid_o | output | 1 | Invalid-operation flag |
| invalid_imz_o | output | 1 | Invalid multiply-by-zero sub-flag |

## Verification
The bench builds the block with its defaults: a registered output stage (REG_OUT = 1) and a three-bit policy select. This makes all eight policy codes reachable, including the two unused ones, and it allows the one-cycle latency and the reset value to be observed. Every policy code is swept over all 64 class combinations with both mode-bit values and both values of the infinity-times-zero indicator. Directed tasks also compare the two mode-bit values against each other under every policy except policy 5. The combinational variant (REG_OUT = 0) is not built by this bench.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    localparam int CLS_W  = 2;
    localparam int PICK_W = 2;
    localparam int OPS    = 3;

    typedef enum logic [PICK_W-1:0] {
        PK_A    = 2'd0,
        PK_B    = 2'd1,
        PK_C    = 2'd2,
        PK_DFLT = 2'd3
    } pick_e;

    localparam logic [2:0] POL_CSNAN_FIRST = 3'd0;
    localparam logic [2:0] POL_LEGACY      = 3'd1;
    localparam logic [2:0] POL_Y2008       = 3'd2;
    localparam logic [2:0] POL_ACB_ANY     = 3'd3;
    localparam logic [2:0] POL_ALWAYS_DFLT = 3'd4;
    localparam logic [2:0] POL_MODAL       = 3'd5;

    // search order: element 0 is checked first
    typedef logic [OPS-1:0][PICK_W-1:0] ord_t;
    localparam ord_t ORD_ABC = {2'd2, 2'd1, 2'd0};
    localparam ord_t ORD_CAB = {2'd1, 2'd0, 2'd2};
    localparam ord_t ORD_ACB = {2'd1, 2'd2, 2'd0};
    localparam ord_t ORD_CBA = {2'd0, 2'd1, 2'd2};

    typedef struct packed {
        logic              found;
        logic [PICK_W-1:0] pick;
    } scan_t;

    typedef struct packed {
        logic [PICK_W-1:0] pick;
        logic              inv;
        logic              imz;
    } verdict_t;

    localparam verdict_t VERDICT_RST = '{pick: PK_DFLT, inv: 1'b0, imz: 1'b0};

    function automatic scan_t first_hit(input logic [OPS-1:0] hit, input ord_t ord);
        scan_t      r;
        logic [3:0] hx;
        hx = {1'b0, hit};
        r.found = 1'b0;
        r.pick  = PK_A;
        for (int k = OPS - 1; k >= 0; k--) begin
            if (hx[ord[k]]) begin
                r.found = 1'b1;
                r.pick  = ord[k];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/opcls_decode.sv
module opcls_decode
    import fma_nan_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output logic             any_nan_o,
    output logic             snan_o,
    output logic             qnan_o
);
    always_comb begin
        any_nan_o = cls_i[1];
        snan_o    = cls_i[1] & cls_i[0];
        qnan_o    = cls_i[1] & ~cls_i[0];
    end
endmodule

// File: rtl/fma_nan_policy.sv
module fma_nan_policy
    import fma_nan_pkg::*;
#(
    parameter int POL_W = 3
) (
    input  logic [POL_W-1:0] policy_i,
    input  logic             mode_i,
    input  logic             iz_i,
    input  logic [OPS-1:0]   nan_i,
    input  logic [OPS-1:0]   snan_i,
    input  logic [OPS-1:0]   qnan_i,
    output verdict_t         verdict_o
);
    localparam int IDX_C = 2;

    scan_t s_abc, q_abc, s_cab, q_cab, n_abc, n_acb, n_cba;

    always_comb begin
        s_abc = first_hit(snan_i, ORD_ABC);
        q_abc = first_hit(qnan_i, ORD_ABC);
        s_cab = first_hit(snan_i, ORD_CAB);
        q_cab = first_hit(qnan_i, ORD_CAB);
        n_abc = first_hit(nan_i,  ORD_ABC);
        n_acb = first_hit(nan_i,  ORD_ACB);
        n_cba = first_hit(nan_i,  ORD_CBA);
    end

    always_comb begin
        verdict_o = '{pick: PK_DFLT, inv: 1'b0, imz: 1'b0};
        case (policy_i)
            POL_W'(POL_CSNAN_FIRST): begin
                if (iz_i && qnan_i[IDX_C]) begin
                    verdict_o = '{pick: PK_DFLT, inv: 1'b1, imz: 1'b1};
                end else if (s_cab.found) begin
                    verdict_o.pick = s_cab.pick;
                end else if (q_cab.found) begin
                    verdict_o.pick = q_cab.pick;
                end else begin
                    verdict_o.pick = PK_B;
                end
            end
            POL_W'(POL_LEGACY): begin
                if (iz_i) begin
                    verdict_o = '{pick: PK_DFLT, inv: 1'b1, imz: 1'b1};
                end else if (s_abc.found) begin
                    verdict_o.pick = s_abc.pick;
                end else if (q_abc.found) begin
                    verdict_o.pick = q_abc.pick;
                end else begin
                    verdict_o.pick = PK_C;
                end
            end
            POL_W'(POL_Y2008): begin
                if (iz_i) begin
                    verdict_o = '{pick: PK_C, inv: 1'b1, imz: 1'b1};
                end else if (s_cab.found) begin
                    verdict_o.pick = s_cab.pick;
                end else if (q_cab.found) begin
                    verdict_o.pick = q_cab.pick;
                end else begin
                    verdict_o.pick = PK_B;
                end
            end
            POL_W'(POL_ACB_ANY): begin
                if (iz_i) begin
                    verdict_o = '{pick: PK_C, inv: 1'b1, imz: 1'b1};
                end else begin
                    verdict_o.pick = n_acb.found ? n_acb.pick : PK_B;
                end
            end
            POL_W'(POL_ALWAYS_DFLT): begin
                verdict_o = '{pick: PK_DFLT, inv: iz_i, imz: iz_i};
            end
            POL_W'(POL_MODAL): begin
                if (iz_i) begin
                    verdict_o = '{pick: PK_C, inv: 1'b1, imz: 1'b1};
                end else if (mode_i) begin
                    verdict_o.pick = n_abc.found ? n_abc.pick : PK_C;
                end else begin
                    verdict_o.pick = n_cba.found ? n_cba.pick : PK_A;
                end
            end
            default: begin
                verdict_o.pick = n_abc.found ? n_abc.pick : PK_C;
            end
        endcase
    end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
#(
    parameter int POL_W   = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POL_W-1:0]  policy_i,
    input  logic              first_nan_i,
    input  logic              inf_zero_i,
    input  logic [CLS_W-1:0]  cls_a_i,
    input  logic [CLS_W-1:0]  cls_b_i,
    input  logic [CLS_W-1:0]  cls_c_i,
    output logic [PICK_W-1:0] pick_o,
    output logic              invalid_o,
    output logic              invalid_imz_o
);
    logic [OPS-1:0][CLS_W-1:0] cls_vec;
    logic [OPS-1:0]            nan_v, snan_v, qnan_v;
    verdict_t                  pol_verdict;
    verdict_t                  vd_d, vd_q;

    always_comb cls_vec = {cls_c_i, cls_b_i, cls_a_i};

    for (genvar g = 0; g < OPS; g++) begin : g_dec
        opcls_decode u_dec (
            .cls_i     (cls_vec[g]),
            .any_nan_o (nan_v[g]),
            .snan_o    (snan_v[g]),
            .qnan_o    (qnan_v[g])
        );
    end

    fma_nan_policy #(.POL_W(POL_W)) u_policy (
        .policy_i  (policy_i),
        .mode_i    (first_nan_i),
        .iz_i      (inf_zero_i),
        .nan_i     (nan_v),
        .snan_i    (snan_v),
        .qnan_i    (qnan_v),
        .verdict_o (pol_verdict)
    );

    always_comb begin
        vd_d = pol_verdict;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vd_q <= VERDICT_RST;
            else        vd_q <= vd_d;
        end

        AST_INV_NEEDS_IZ: assert property (@(posedge clk) disable iff (!rst_n)
            !inf_zero_i |=> !invalid_o); // R10
        AST_IMZ_WITH_INV: assert property (@(posedge clk) disable iff (!rst_n)
            invalid_o == invalid_imz_o); // R10
        AST_ALWAYS_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_i == POL_W'(POL_ALWAYS_DFLT)) |=> (pick_o == PK_DFLT)); // R6
        AST_LEGACY_IZ: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_i == POL_W'(POL_LEGACY) && inf_zero_i) |=> (pick_o == PK_DFLT && invalid_o)); // R3
        AST_Y2008_IZ: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_i == POL_W'(POL_Y2008) && inf_zero_i) |=> (pick_o == PK_C && invalid_o)); // R4
        AST_UNUSED_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_i > POL_W'(POL_MODAL)) |=> !invalid_o); // R9
    end else begin : g_comb
        always_comb vd_q = vd_d;
    end

    always_comb begin
        pick_o        = vd_q.pick;
        invalid_o     = vd_q.inv;
        invalid_imz_o = vd_q.imz;
    end
endmodule

// File: tb/tb_fma_nan_select.sv
module tb_fma_nan_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] policy_i = '0;
    logic       first_nan_i = 1'b0;
    logic       inf_zero_i = 1'b0;
    logic [1:0] cls_a_i = '0, cls_b_i = '0, cls_c_i = '0;
    logic [1:0] pick_o;
    logic       invalid_o, invalid_imz_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fma_nan_select dut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .first_nan_i(first_nan_i),
        .inf_zero_i(inf_zero_i), .cls_a_i(cls_a_i), .cls_b_i(cls_b_i), .cls_c_i(cls_c_i),
        .pick_o(pick_o), .invalid_o(invalid_o), .invalid_imz_o(invalid_imz_o)
    );

    // independent reference built from the requirement text
    function automatic void model(input int p, input bit m, input bit iz,
                                  input logic [1:0] ca, input logic [1:0] cb, input logic [1:0] cc,
                                  output logic [1:0] pk, output bit inv, output string tag);
        bit na = ca[1], nb = cb[1], nc = cc[1];
        bit sa = (ca == 2'b11), sb = (cb == 2'b11), sc = (cc == 2'b11);
        bit qa = (ca == 2'b10), qb = (cb == 2'b10), qc = (cc == 2'b10);
        inv = 1'b0;
        case (p)
            0: begin
                tag = "R2";
                if (iz && qc) begin pk = 3; inv = 1; end
                else pk = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
            end
            1: begin
                tag = "R3";
                if (iz) begin pk = 3; inv = 1; end
                else pk = sa ? 0 : sb ? 1 : sc ? 2 : qa ? 0 : qb ? 1 : 2;
            end
            2: begin
                tag = "R4";
                if (iz) begin pk = 2; inv = 1; end
                else pk = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
            end
            3: begin
                tag = "R5";
                if (iz) begin pk = 2; inv = 1; end
                else pk = na ? 0 : nc ? 2 : 1;
            end
            4: begin
                tag = "R6";
                pk = 3; inv = iz;
            end
            5: begin
                tag = m ? "R7" : "R8";
                if (iz) begin pk = 2; inv = 1; end
                else if (m) pk = na ? 0 : nb ? 1 : 2;
                else        pk = nc ? 2 : nb ? 1 : 0;
            end
            default: begin
                tag = "R9";
                pk = na ? 0 : nb ? 1 : 2;
            end
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive at negedge; result is registered at the next posedge; sample at the following negedge
    task automatic apply(input int p, input bit m, input bit iz,
                         input logic [1:0] ca, input logic [1:0] cb, input logic [1:0] cc);
        policy_i = p[2:0]; first_nan_i = m; inf_zero_i = iz;
        cls_a_i = ca; cls_b_i = cb; cls_c_i = cc;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset pick", pick_o, 3);
        check("R1", "reset invalid", invalid_o, 0);
        check("R1", "reset imz", invalid_imz_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        // policy 1, a signaling: pick 0 appears after one edge
        apply(4, 0, 0, 0, 0, 0);
        policy_i = 3'd1; cls_a_i = 2'b11;
        @(posedge clk); #1;
        check("R1", "pick after one edge", pick_o, 0);
        @(negedge clk);
        check("R1", "pick held", pick_o, 0);
    endtask

    task automatic t_sweep(input int p);
        logic [1:0] epk; bit einv; string tag;
        for (int m = 0; m < 2; m++)
            for (int iz = 0; iz < 2; iz++)
                for (int v = 0; v < 64; v++) begin
                    apply(p, m[0], iz[0], v[1:0], v[3:2], v[5:4]);
                    model(p, m[0], iz[0], v[1:0], v[3:2], v[5:4], epk, einv, tag);
                    check(tag, $sformatf("pick p=%0d m=%0d iz=%0d v=%0d", p, m, iz, v), pick_o, epk);
                    check(tag, "invalid", invalid_o, einv);
                    check("R10", "imz sub-flag", invalid_imz_o, einv);
                end
    endtask

    task automatic t_mode_ignored();
        for (int p = 0; p < 8; p++) begin
            if (p == 5) continue;
            for (int iz = 0; iz < 2; iz++)
                for (int v = 0; v < 64; v++) begin
                    int r0;
                    apply(p, 1'b0, iz[0], v[1:0], v[3:2], v[5:4]);
                    r0 = {pick_o, invalid_o, invalid_imz_o};
                    apply(p, 1'b1, iz[0], v[1:0], v[3:2], v[5:4]);
                    check("R11", $sformatf("mode bit effect p=%0d v=%0d", p, v),
                          {pick_o, invalid_o, invalid_imz_o}, r0);
                end
        end
    endtask

    task automatic t_corners();
        // policy 0, inf*zero with c signaling: no invalid, c chosen
        apply(0, 0, 1, 2'b00, 2'b00, 2'b11);
        check("R2", "iz with c signaling pick", pick_o, 2);
        check("R2", "iz with c signaling invalid", invalid_o, 0);
        // policy 0, inf*zero with c quiet: default
        apply(0, 0, 1, 2'b11, 2'b00, 2'b10);
        check("R2", "iz with c quiet pick", pick_o, 3);
        check("R10", "iz with c quiet imz", invalid_imz_o, 1);
        // unused code 7 with inf*zero: no flag
        apply(7, 0, 1, 2'b00, 2'b00, 2'b00);
        check("R9", "code 7 iz pick", pick_o, 2);
        check("R9", "code 7 iz invalid", invalid_o, 0);
        // policy 5 mode clear, no NaN: a
        apply(5, 0, 0, 2'b01, 2'b00, 2'b01);
        check("R8", "no NaN pick", pick_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        for (int p = 0; p < 8; p++) t_sweep(p);
        t_mode_ignored();
        t_corners();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule